// File: doc/BRIEF.md
# Gated IF Frequency Counter with Serial Status Readout

This block measures an intermediate-frequency signal by counting its rising edges during a gate window. The window is a fixed number of reference ticks, picked from four lengths by a 2-bit select. A start pulse clears the count and opens the window. While the window is open, each rising edge of the IF input adds one to the count, and the count stops at all ones rather than wrapping. A done flag rises when the window closes. After that, further edges have no effect.

A load pulse captures a status snapshot into a shift register, all in one cycle. The snapshot holds the two port pin levels, the lock flag and the frequency count. The controller reads the snapshot out one bit at a time over a chip-enable and serial-clock pair. The data bit advances on each falling serial-clock edge, so it is steady when the controller samples on the rising edge. The data line is held low whenever chip-enable is low. Everything runs on one system clock. The serial clock and the IF input are sampled as levels, and their edges are detected against the previous sample.

Top module: `if_count_status`

## Requirements
- R1: After reset, `done` is 0, `dout` is 0 and the held count is 0.
- R2: A `count_start` pulse clears the count and `done` and opens a gate window. The window length in `ref_tick` pulses follows `gate_sel`: 0 gives 4, 1 gives 8, 2 gives 32 and 3 gives 64. `done` is 1 in the cycle after the last tick of the window is sampled, and is 0 before that.
- R3: Each rising edge of `if_in` that is sampled while the window is open adds one to the count. Edges that arrive after the window has closed leave the count unchanged.
- R4: When the count reaches all ones, it holds that value. It never wraps to zero.
- R5: An `out_load` pulse captures a snapshot of CW+3 bits, in this order from MSB to LSB: `io2_pin`, `io1_pin`, `lock_ok`, then count bits CW-1 down to 0. A pin that is high reads 1. `lock_ok` is 1 for locked or detection stopped, and 0 for unlocked.
- R6: Once captured, the snapshot does not change when the pins, the lock flag or the count change later.
- R7: While `ce` is high, `dout` shows the current MSB of the snapshot. Each falling edge of `sclk` moves the next bit onto `dout`, so the bits appear in the R5 order.
- R8: While `ce` is low, `dout` is 0, and falling edges of `sclk` do not advance the snapshot.
- R9: The window length is fixed when `count_start` occurs. Later changes to `gate_sel` during the window do not change when `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_in | input | 1 | IF signal level to be counted |
| ref_tick | input | 1 | One-cycle pulse for each gate time-base tick |
| gate_sel | input | 2 | Gate length select |
| count_start | input | 1 | Pulse that clears the count and opens the window |
| lock_ok | input | 1 | Lock flag: 1 for locked or detection stopped |
| io1_pin | input | 1 | Level of port pin 1 |
| io2_pin | input | 1 | Level of port pin 2 |
| out_load | input | 1 | Pulse that captures the status snapshot |
| ce | input | 1 | Serial chip enable |
| sclk | input | 1 | Serial clock level |
| dout | output | 1 | Serial data bit |
| done | output | 1 | High once the gate window has closed |

## Verification
The assertions check four things on every cycle: the count holds still at saturation and whenever the window is closed, `done` rises only out of an open window, and the snapshot moves only as loads and falling serial-clock edges allow. The bench scenarios cover what the assertions cannot see: exact counts for several edge totals and gate lengths, the rise of `done` on the final tick, the full bit order of the serial word, snapshot isolation from later pin changes, and the data line staying low and frozen while chip-enable is low.

// File: rtl/if_count_status.sv
module if_count_status #(
  parameter int CW    = 20,
  parameter int GLEN0 = 4,
  parameter int GLEN1 = 8,
  parameter int GLEN2 = 32,
  parameter int GLEN3 = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_in,
  input  logic       ref_tick,
  input  logic [1:0] gate_sel,
  input  logic       count_start,
  input  logic       lock_ok,
  input  logic       io1_pin,
  input  logic       io2_pin,
  input  logic       out_load,
  input  logic       ce,
  input  logic       sclk,
  output logic       dout,
  output logic       done
);
  localparam int WW   = CW + 3;
  localparam int GM01 = (GLEN0 > GLEN1) ? GLEN0 : GLEN1;
  localparam int GM23 = (GLEN2 > GLEN3) ? GLEN2 : GLEN3;
  localparam int GMAX = (GM01 > GM23) ? GM01 : GM23;
  localparam int TW   = $clog2(GMAX + 1);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt, glen;
  logic [1:0]    gsel_q;
  logic          gate_open, if_q, sclk_q;
  logic [WW-1:0] sh;

  wire if_rise = if_in & ~if_q;
  wire sfall   = ce & sclk_q & ~sclk;
  wire last    = ref_tick && (tcnt + 1'b1 == glen);

  always_comb
    case (gsel_q)
      2'd0:    glen = TW'(GLEN0);
      2'd1:    glen = TW'(GLEN1);
      2'd2:    glen = TW'(GLEN2);
      default: glen = TW'(GLEN3);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      if_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      if_q   <= if_in;
      sclk_q <= sclk;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt       <= '0;
      tcnt      <= '0;
      gsel_q    <= 2'd0;
      gate_open <= 1'b0;
      done      <= 1'b0;
    end else if (count_start) begin
      cnt       <= '0;
      tcnt      <= '0;
      gsel_q    <= gate_sel;
      gate_open <= 1'b1;
      done      <= 1'b0;
    end else if (gate_open) begin
      if (if_rise && cnt != CMAX) cnt <= cnt + 1'b1;
      if (last) begin
        gate_open <= 1'b0;
        done      <= 1'b1;
      end else if (ref_tick) begin
        tcnt <= tcnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sh <= '0;
    else if (out_load) sh <= {io2_pin, io1_pin, lock_ok, cnt};
    else if (sfall)    sh <= {sh[WW-2:0], 1'b0};

  assign dout = ce & sh[WW-1];

  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !count_start) |=> cnt == CMAX);
  a_r3_hold_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && !count_start) |=> $stable(cnt));
  a_r2_done_from_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(gate_open));
  a_r8_frozen_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !out_load) |=> $stable(sh));
  a_r7_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && sclk_q && !sclk && !out_load) |=> sh[WW-1] == $past(sh[WW-2]));
endmodule

// File: tb/if_count_status_test.sv
`timescale 1ns/1ps
module if_count_status_test;
  logic clk = 0, rst_n = 0;
  logic if_in = 0, ref_tick = 0, count_start = 0, lock_ok = 0;
  logic io1 = 0, io2 = 0, out_load = 0, ce = 0, sclk = 0;
  logic [1:0] gate_sel = 0;
  logic dout, done, dout_s, done_s;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  if_count_status uut (.clk, .rst_n, .if_in, .ref_tick, .gate_sel, .count_start,
    .lock_ok, .io1_pin(io1), .io2_pin(io2), .out_load, .ce, .sclk, .dout, .done);
  if_count_status #(.CW(4)) uut_sat (.clk, .rst_n, .if_in, .ref_tick, .gate_sel,
    .count_start, .lock_ok, .io1_pin(io1), .io2_pin(io2), .out_load, .ce, .sclk,
    .dout(dout_s), .done(done_s));

  // gsel[10:9] edges[8:3] io2[2] io1[1] lock[0]
  localparam logic [10:0] VEC [6] = '{
    {2'd0, 6'd0,  3'b001}, {2'd1, 6'd5,  3'b100}, {2'd2, 6'd37, 3'b011},
    {2'd3, 6'd63, 3'b110}, {2'd0, 6'd1,  3'b111}, {2'd2, 6'd42, 3'b000}};

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_start(); count_start = 1; cyc(1); count_start = 0; endtask
  task automatic pulse_load();  out_load = 1; cyc(1); out_load = 0; endtask
  task automatic tick();        ref_tick = 1; cyc(1); ref_tick = 0; cyc(1); endtask
  task automatic edges(int n);
    for (int i = 0; i < n; i++) begin if_in = 1; cyc(1); if_in = 0; cyc(1); end
  endtask
  task automatic sfall(); sclk = 1; cyc(1); sclk = 0; cyc(1); endtask

  task automatic readw(output logic [22:0] w, output logic [6:0] ws);
    ce = 1; cyc(1);
    for (int i = 22; i >= 0; i--) begin
      w[i] = dout;
      if (i >= 16) ws[i-16] = dout_s;
      if (i > 0) sfall();
    end
    ce = 0; cyc(1);
  endtask

  int glen_of [4] = '{4, 8, 32, 64};

  initial begin
    logic [22:0] w, exp;
    logic [6:0] ws;
    cyc(3); rst_n = 1; cyc(1);
    chk("R1 done", done, 0);
    chk("R1 dout", dout, 0);
    ce = 1; cyc(1); chk("R1 dout ce", dout, 0); ce = 0;
    pulse_load(); readw(w, ws);
    chk("R1 count", w, 0);

    for (int v = 0; v < 6; v++) begin
      int gs = VEC[v][10:9];
      int ne = VEC[v][8:3];
      gate_sel = 2'(gs);
      pulse_start();
      gate_sel = ~2'(gs); // R9: changes after start ignored
      edges(ne);
      for (int t = 0; t < glen_of[gs] - 1; t++) tick();
      chk("R2 R9 done early", done, 0);
      tick();
      chk("R2 R9 done on last tick", done, 1);
      edges(3); // R3: after close
      {io2, io1, lock_ok} = VEC[v][2:0];
      cyc(1);
      pulse_load();
      {io2, io1, lock_ok} = ~VEC[v][2:0]; // R6
      exp = {VEC[v][2:0], 20'(ne)};
      readw(w, ws);
      chk("R3 R5 R6 R7 word", w, exp);
    end

    // R4 saturation on the narrow instance
    gate_sel = 2'd1; pulse_start(); edges(20);
    for (int t = 0; t < 8; t++) tick();
    {io2, io1, lock_ok} = 3'b101; cyc(1);
    pulse_load(); readw(w, ws);
    chk("R4 saturate", ws, 7'b101_1111);
    chk("R3 count 20", w[19:0], 20);

    // R8: ce low blocks shifting and forces dout low
    {io2, io1, lock_ok} = 3'b111; cyc(1); pulse_load();
    chk("R8 dout low", dout, 0);
    sfall(); sfall();
    ce = 1; cyc(1);
    chk("R8 no shift bit io2", dout, 1);
    sfall(); chk("R7 bit io1", dout, 1);
    sfall(); chk("R7 bit lock", dout, 1);
    ce = 0; cyc(1); chk("R8 dout low again", dout, 0);
    {io2, io1, lock_ok} = 3'b010; cyc(1); pulse_load();
    ce = 1; cyc(1); chk("R5 io2 low", dout, 0);
    sfall(); chk("R5 io1 high", dout, 1);
    ce = 0;

    // R2 restart clears count mid-window
    gate_sel = 2'd0; pulse_start(); edges(7);
    pulse_start(); edges(2);
    for (int t = 0; t < 4; t++) tick();
    pulse_load(); readw(w, ws);
    chk("R2 restart clears", w[19:0], 2);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule